// File: doc/BRIEF.md
# Power-Good Qualifier with Transition Blanking

This block generates the power-good indication of a CPU core regulator. A window comparator reports whether the regulated output sits within ±10% of its present target. The block turns that flag into an open-drain pull-low enable. The enable is held active until soft-start reports that it is armed. The block then combines the internal result with the chipset's own good signal, so that both must agree before the line is released.

Any move of the target hides faults for a fixed interval, because the output is then still slewing. A move of the target is a change of the voltage-identification code, an entry to or exit from deep sleep (stop input low), or an entry to or exit from deeper sleep (deeper-sleep input high). While this blanking interval runs, the internal result is frozen at the value it had just before the move. A further move inside the interval restarts the full count. When the interval ends, the live window flag is used again.

In deeper sleep the target is fixed regardless of the identification code. Code changes are therefore not treated as moves in that state. All asynchronous inputs pass through two-flop synchronizers before use.

Top module: `pgood_qualifier`

## Requirements
- R1: Once armed, with the chipset good and no blanking running, `pull_low_o` equals the inverse of the window flag. A level change on `in_window_i` reaches `pull_low_o` after the third rising edge.
- R2: A change of `vid_i`, `stop_cpu_n_i` or `deeper_sleep_i` starts a blanking interval that lasts `BLANK_CYCLES` cycles after the cycle in which the change is detected.
- R3: A further change detected while blanking runs reloads the full `BLANK_CYCLES` count.
- R4: If the window flag is low when blanking ends, `pull_low_o` goes to 1.
- R5: An out-of-window condition that starts and ends inside the blanking interval never reaches `pull_low_o`. A single window flag carries both the overvoltage and the undervoltage direction.
- R6: During blanking the internal result keeps the value it had just before the triggering change, whether that value was good or bad.
- R7: While `ss_armed_i` is low, `pull_low_o` is 1, even during blanking.
- R8: `pull_low_o` is 1 whenever `chipset_good_i` is low. The composite good is the AND of the internal result and the chipset input.
- R9: While `deeper_sleep_i` is 1, changes of `vid_i` start no blanking.
- R10: A synchronous active-low reset forces `pull_low_o` to 1 and clears the blanking timer. Inputs held steady across reset release produce no spurious change.
- R11: `pull_low_o` = 1 means the output is driven low; 0 means high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_i | input | VID_W | Voltage-identification code (asynchronous) |
| stop_cpu_n_i | input | 1 | Low selects deep sleep (asynchronous) |
| deeper_sleep_i | input | 1 | High selects deeper sleep (asynchronous) |
| in_window_i | input | 1 | 1 when the output is within ±10% of target (asynchronous) |
| chipset_good_i | input | 1 | Chipset power-good (asynchronous) |
| ss_armed_i | input | 1 | Soft-start has reached its arming level (asynchronous) |
| pull_low_o | output | 1 | Open-drain enable: 1 drives the power-good line low |

## Verification
The bench builds the block with `BLANK_CYCLES` = 20, `VID_W` = 7 and two synchronizer stages. With a 20-cycle interval, mask expiry, restart by a second change, and faults that come and go inside the interval can all be placed precisely within a few dozen cycles. The default of 13750 cycles would hide these boundaries behind long waits. Directed probes are placed well inside and well past each interval, and a behavioural model checks the exact cycle of every edge.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Control levels that share one synchronizer bank.
    typedef struct packed {
        logic stop_n;
        logic deeper;
        logic in_win;
        logic cg_good;
        logic armed;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Registered result of the qualifier.
    typedef struct packed {
        logic int_good;
        logic pull_low;
    } out_st_t;

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef logic [W-1:0] stage_t;

    stage_t chain_d [STAGES];
    stage_t chain_q [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pg_change_det.sv
module pg_change_det #(
    parameter int VID_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid_i,
    input  logic             stop_n_i,
    input  logic             deeper_i,
    output logic             chg_o
);
    typedef struct packed {
        logic [VID_W-1:0] vid;
        logic             stop_n;
        logic             deeper;
    } snap_t;

    snap_t cur, prev_d, prev_q;
    logic  vid_moved, stop_moved, deeper_moved;

    always_comb begin
        cur.vid    = vid_i;
        cur.stop_n = stop_n_i;
        cur.deeper = deeper_i;

        vid_moved    = (cur.vid    != prev_q.vid);
        stop_moved   = (cur.stop_n != prev_q.stop_n);
        deeper_moved = (cur.deeper != prev_q.deeper);

        // In deeper sleep the target ignores the code, so a code move alone is no event.
        chg_o = rst_n & (deeper_moved | stop_moved | (vid_moved & ~cur.deeper));

        // Track present value every cycle, also in reset, so release is clean.
        prev_d = cur;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

endmodule

// File: rtl/pg_blank_timer.sv
module pg_blank_timer #(
    parameter int BLANK_CYCLES = 13750,
    parameter int CNT_W        = $clog2(BLANK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic             mask_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!rst_n) begin
            cnt_d = '0;
        end else if (restart_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign mask_o = restart_i | (cnt_q != '0);
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/pgood_qualifier.sv
module pgood_qualifier #(
    parameter int VID_W        = 7,
    parameter int BLANK_CYCLES = 13750,
    parameter int SYNC_STAGES  = 2,
    localparam int CNT_W       = $clog2(BLANK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid_i,
    input  logic             stop_cpu_n_i,
    input  logic             deeper_sleep_i,
    input  logic             in_window_i,
    input  logic             chipset_good_i,
    input  logic             ss_armed_i,
    output logic             pull_low_o
);
    import pg_pkg::*;

    ctl_t              ctl_raw, ctl_s;
    logic [CTL_W-1:0]  ctl_bits;
    logic [VID_W-1:0]  vid_s;
    logic              chg;
    logic              mask_on;
    logic [CNT_W-1:0]  cnt;
    out_st_t           st_d, st_q;
    logic              int_good_q;
    logic              arm_s, cg_s, win_s;

    always_comb begin
        ctl_raw.stop_n  = stop_cpu_n_i;
        ctl_raw.deeper  = deeper_sleep_i;
        ctl_raw.in_win  = in_window_i;
        ctl_raw.cg_good = chipset_good_i;
        ctl_raw.armed   = ss_armed_i;
    end

    pg_sync #(.W(VID_W), .STAGES(SYNC_STAGES)) u_vid_sync (
        .clk (clk),
        .d_i (vid_i),
        .q_o (vid_s)
    );

    pg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk (clk),
        .d_i (ctl_raw),
        .q_o (ctl_bits)
    );

    assign ctl_s = ctl_t'(ctl_bits);
    assign arm_s = ctl_s.armed;
    assign cg_s  = ctl_s.cg_good;
    assign win_s = ctl_s.in_win;

    pg_change_det #(.VID_W(VID_W)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_i    (vid_s),
        .stop_n_i (ctl_s.stop_n),
        .deeper_i (ctl_s.deeper),
        .chg_o    (chg)
    );

    pg_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES), .CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (chg),
        .mask_o    (mask_on),
        .cnt_o     (cnt)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.int_good = 1'b0;
            st_d.pull_low = 1'b1;
        end else begin
            if (!mask_on) begin
                st_d.int_good = win_s;
            end
            st_d.pull_low = ~(arm_s & cg_s & st_d.int_good);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign int_good_q = st_q.int_good;
    assign pull_low_o = st_q.pull_low;

endmodule

// File: rtl/pgood_checks.sv
module pgood_checks #(
    parameter int BLANK_CYCLES = 13750,
    parameter int CNT_W        = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pull_low_o,
    input logic             arm_s,
    input logic             cg_s,
    input logic             win_s,
    input logic             chg,
    input logic             mask_on,
    input logic [CNT_W-1:0] cnt,
    input logic             int_good_q
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYCLES);

    assert_unarmed_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_s |=> pull_low_o);

    assert_chipset_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cg_s |=> pull_low_o);

    assert_frozen_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_on |=> $stable(int_good_q));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (cnt == LOAD));

    assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_fault_after_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_on && !win_s) |=> pull_low_o);

endmodule

bind pgood_qualifier pgood_checks #(.BLANK_CYCLES(BLANK_CYCLES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_low_o (pull_low_o),
    .arm_s      (arm_s),
    .cg_s       (cg_s),
    .win_s      (win_s),
    .chg        (chg),
    .mask_on    (mask_on),
    .cnt        (cnt),
    .int_good_q (int_good_q)
);

// File: tb/sim_pgood_qualifier.sv
`timescale 1ns/1ps
module sim_pgood_qualifier;
    localparam int VID_W = 7;
    localparam int BLANK = 20;
    localparam int SW    = VID_W + 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VID_W-1:0] vid = 7'h20;
    logic             stop_n = 1'b1;
    logic             deeper = 1'b0;
    logic             win = 1'b1;
    logic             cg = 1'b1;
    logic             arm = 1'b0;
    logic             pull_low;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pgood_qualifier #(.VID_W(VID_W), .BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .vid_i          (vid),
        .stop_cpu_n_i   (stop_n),
        .deeper_sleep_i (deeper),
        .in_window_i    (win),
        .chipset_good_i (cg),
        .ss_armed_i     (arm),
        .pull_low_o     (pull_low)
    );

    // Behavioural reference: sample history queue, integer timer.
    // Sample layout: {vid, stop_n, deeper, win, cg, arm}.
    logic [SW-1:0] hist[$];
    logic [SW-1:0] m_prev = '0;
    logic [SW-1:0] s_old;
    int            m_cnt = 0;
    bit            m_ig = 1'b0;
    bit            m_pl = 1'b1;
    bit            m_chg;

    always @(posedge clk) begin
        cyc++;
        s_old = (hist.size() == 2) ? hist[0] : '0;
        if (!rst_n) begin
            m_cnt = 0;
            m_ig  = 1'b0;
            m_pl  = 1'b1;
        end else begin
            m_chg = (s_old[4] != m_prev[4]) || (s_old[3] != m_prev[3]) ||
                    ((s_old[SW-1:5] != m_prev[SW-1:5]) && !s_old[3]);
            if (!(m_chg || m_cnt > 0)) m_ig = s_old[2];
            if (m_chg) m_cnt = BLANK;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_pl = !(s_old[0] && m_ig && s_old[1]);
        end
        m_prev = s_old;
        hist.push_back({vid, stop_n, deeper, win, cg, arm});
        if (hist.size() > 2) void'(hist.pop_front());
    end

    always @(negedge clk) begin
        if (cyc >= 2) begin
            checks++;
            if (pull_low !== m_pl) begin
                failures++;
                $display("FAIL R1 model cycle %0d: pull_low actual=%0b expected=%0b", cyc, pull_low, m_pl);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pl(input bit exp, input string req);
        checks++;
        if (pull_low !== exp) begin
            failures++;
            $display("FAIL %s: pull_low actual=%0b expected=%0b", req, pull_low, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(5);
        expect_pl(1'b1, "R10 reset drives low");
        rst_n = 1'b1;
        tick(5);
        expect_pl(1'b1, "R7 held low before arming");
        arm = 1'b1;
        tick(4);
        expect_pl(1'b0, "R11 released when good");
        win = 1'b0;
        tick(4);
        expect_pl(1'b1, "R1 out of window drives low");
        win = 1'b1;
        tick(4);
        expect_pl(1'b0, "R1 back in window releases");

        // R2 / R4: code change with simultaneous fault
        vid = 7'h21; win = 1'b0;
        tick(10);
        expect_pl(1'b0, "R2 fault hidden after code change");
        tick(16);
        expect_pl(1'b1, "R4 fault reported after mask");
        win = 1'b1;
        tick(4);
        expect_pl(1'b0, "R1 recovery");

        // R3: restart by second change
        vid = 7'h22;
        tick(12);
        vid = 7'h23;
        tick(2);
        win = 1'b0;
        tick(12);
        expect_pl(1'b0, "R3 mask restarted by second change");
        tick(12);
        expect_pl(1'b1, "R3 fault shown after restarted mask");
        win = 1'b1;
        tick(4);
        expect_pl(1'b0, "R1 recovery 2");

        // R5: deep sleep entry, transient fault inside the mask
        stop_n = 1'b0;
        tick(2);
        win = 1'b0;
        tick(8);
        expect_pl(1'b0, "R5 transient fault hidden");
        win = 1'b1;
        tick(20);
        expect_pl(1'b0, "R5 transient never reported");

        // R6: bad value held through deeper-sleep entry
        win = 1'b0;
        tick(4);
        expect_pl(1'b1, "R1 fault before change");
        deeper = 1'b1; win = 1'b1;
        tick(8);
        expect_pl(1'b1, "R6 prior bad value held in mask");
        tick(20);
        expect_pl(1'b0, "R6 live flag used after mask");

        // R9: code change in deeper sleep is no event
        vid = 7'h24; win = 1'b0;
        tick(5);
        expect_pl(1'b1, "R9 code change in deeper sleep not masked");
        win = 1'b1;
        tick(4);
        expect_pl(1'b0, "R9 recovery");

        // R8: chipset good
        cg = 1'b0;
        tick(4);
        expect_pl(1'b1, "R8 chipset not good");
        cg = 1'b1;
        tick(4);
        expect_pl(1'b0, "R8 chipset good again");

        // R7 during mask
        deeper = 1'b0;
        tick(5);
        arm = 1'b0;
        tick(4);
        expect_pl(1'b1, "R7 disarm overrides mask");
        arm = 1'b1;
        tick(4);
        expect_pl(1'b0, "R7 rearm inside mask uses held good");

        // R10: reset clears running timer
        tick(30);
        vid = 7'h25; win = 1'b0;
        tick(5);
        expect_pl(1'b0, "R2 masked before reset");
        rst_n = 1'b0;
        win = 1'b1;
        tick(4);
        expect_pl(1'b1, "R10 reset forces low");
        rst_n = 1'b1;
        tick(4);
        expect_pl(1'b0, "R10 timer cleared by reset");
        tick(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule